// File: doc/BRIEF.md
# Prescaled Four-Channel Down-Counting Timer Bank

This block is a register-mapped timer peripheral. A 12-bit prescaler counts system clocks down and emits a one-cycle tick each time it wraps. On each tick a sequencer walks the timer slots in index order, one slot per clock. A single subtractor is shared by all slots, so only one 32-bit decrement is built however many timers there are.

Each timer has a counter, a reload register and a control word. The control word holds run, auto-restart, load, interrupt-enable, interrupt-pending, cascade and debug-freeze bits. A cascaded timer steps only when the slot just before it wraps in the same pass, so two to four slots can be joined into one longer count. The last slot also drives an active-low watchdog line. Software keeps that line high by reloading the last slot before it expires.

Software reaches the block through a plain 32-bit word bus with a combinational read path. The block has one interrupt pulse line per timer and one debug-halt input.

Top module: `cascade_timer_bank`

## Requirements
- R1: The prescaler value (offset 0x00, bits 11:0) and prescaler reload (offset 0x04, bits 11:0) are readable and writable. When the value is 0 at a clock edge it reloads from the reload register and gives one tick, so ticks come every reload+1 clocks.
- R2: On each tick the slots are visited in index order, one per clock. An enabled, unfrozen, uncascaded timer steps its counter down by exactly one per tick.
- R3: With a prescaler reload of 4 or more (division by 5 or more), no tick is lost. A tick that arrives while a pass is still running is dropped.
- R4: Timer n sits at 0x10+16n (counter), 0x14+16n (reload) and 0x18+16n (control). The control bits are bit0 run, bit1 restart, bit2 load, bit3 irq-enable, bit4 pending, bit5 cascade and bit6 debug-freeze.
- R5: Writing the control word with bit2=1 copies the reload value into the counter at once. Bit2 always reads back as 0.
- R6: A timer that steps while its counter is 0 wraps. With restart=1 it reloads, so a lone timer with reload L and prescaler reload P interrupts every (L+1)(P+1) clocks.
- R7: With restart=0, a wrap leaves the counter at all ones and clears the run bit.
- R8: A wrap with irq-enable=1 sets the pending bit and raises irq_o[n] for exactly one clock. With irq-enable=0 there is no pulse and the pending bit stays 0. Writing 0 to the pending bit clears it, and writing 1 to it has no effect.
- R9: A cascaded timer steps only when the previous slot wraps in the same pass. Timer 0 with cascade=1 never steps, and a stopped predecessor never advances its successor.
- R10: wdog_n_o goes low when the last timer wraps and stays low until a load write to the last timer. Load writes made before expiry keep it high.
- R11: The configuration word (offset 0x08) reads bits 2:0 = 4 timers, bits 7:3 = 6 (first interrupt number), bit8 = 1 (separate interrupts) and bit9 = freeze-override. Only bit9 is writable.
- R12: While dbg_halt_i=1 and bit9 of the configuration word is 0, a timer with debug-freeze set holds its count. With bit9=1 it keeps running.
- R13: After reset all counters, reloads and control words are 0, the prescaler reload reads 0xFFF, the configuration word reads 0x134, wdog_n_o is 1 and no interrupt is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| dbg_halt_i | input | 1 | Debug halt request |
| irq_o | output | 4 | Per-timer one-clock interrupt pulses |
| wdog_n_o | output | 1 | Active-low watchdog expiry |

## Verification
A wrong pass order or a lost tick in the sequencer shows up at the ports as a wrong interrupt interval within one timer period. It also shows as a counter that falls by a different amount over a fixed window of whole prescaler periods. A cascade fault appears on the successor's interrupt line after one full predecessor period. A pending-bit or run-bit fault appears in the very next control-word read. A watchdog latch fault shows on wdog_n_o within one clock of the last slot's wrap or of the load write that should clear it.

// File: rtl/ctb_pkg.sv
// Package: shared bit positions and constants for the timer bank.
// Assumes a 7-bit control word whose layout is fixed by software.
package ctb_pkg;
    localparam int CTL_W   = 7;
    localparam int B_RUN   = 0;
    localparam int B_RST   = 1;
    localparam int B_LOAD  = 2;
    localparam int B_IEN   = 3;
    localparam int B_PEND  = 4;
    localparam int B_CASC  = 5;
    localparam int B_FRZ   = 6;
    localparam int CFG_OVR = 9;
endpackage

// File: rtl/ctb_prescaler.sv
// Module: prescaler down counter. Emits a one-cycle tick when the value is 0
// and reloads in the same edge. Assumes software keeps reload >= 4.
module ctb_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val,
    input  logic             wr_rld,
    input  logic [PRE_W-1:0] wdata,
    output logic [PRE_W-1:0] val_o,
    output logic [PRE_W-1:0] rld_o,
    output logic             tick_o
);
    logic [PRE_W-1:0] val_q, rld_q;

    assign tick_o = (val_q == '0) && !wr_val;
    assign val_o  = val_q;
    assign rld_o  = rld_q;

    // Count down, self-reload on zero, accept software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '1;
            rld_q <= '1;
        end else begin
            if (wr_rld) rld_q <= wdata;
            if (wr_val)             val_q <= wdata;
            else if (val_q == '0)   val_q <= rld_q;
            else                    val_q <= val_q - 1'b1;
        end
    end

    AST_PRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> val_q == $past(rld_q)); // R1
endmodule

// File: rtl/ctb_sequencer.sv
// Module: pass sequencer. A tick starts a pass that grants one slot per
// clock in index order. Ticks arriving mid-pass are dropped.
module ctb_sequencer #(
    parameter int NUM = 4,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [NUM-1:0]   go_o
);
    logic             active_q;
    logic [IDX_W-1:0] idx_q;

    assign idx_o = idx_q;

    // Start a pass on a tick, advance the slot index, end after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (active_q) begin
            if (idx_q == IDX_W'(NUM-1)) active_q <= 1'b0;
            else                        idx_q    <= idx_q + 1'b1;
        end else if (tick_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end
    end

    for (genvar k = 0; k < NUM; k++) begin : g_go
        assign go_o[k] = active_q && (idx_q == IDX_W'(k));
        if (k > 0) begin : g_ord
            AST_PASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                go_o[k] |-> $past(go_o[k-1])); // R2
        end
    end

    AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_o[0]) |-> $past(tick_i)); // R3
endmodule

// File: rtl/ctb_slot.sv
// Module: one timer slot. Holds counter, reload and control state. Steps
// only in its granted cycle, using the shared decrement result dec_i.
module ctb_slot
    import ctb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wdata,
    input  logic             go_i,
    input  logic             chain_i,
    input  logic             halt_i,
    input  logic [CNT_W-1:0] dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             wrap_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q, rld_q;
    logic run_q, rst_q, ien_q, pend_q, casc_q, frz_q, irq_q;
    logic step, wrap, ld_wr;

    assign step   = go_i && run_q && !(frz_q && halt_i) && (casc_q ? chain_i : 1'b1);
    assign wrap   = step && (cnt_q == '0);
    assign ld_wr  = wr_ctl && wdata[B_LOAD];
    assign wrap_o = wrap;
    assign irq_o  = irq_q;
    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;
    assign ctl_o  = {frz_q, casc_q, pend_q, ien_q, 1'b0, rst_q, run_q};

    // Counter: bus write, then load, then step or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (wr_cnt)    cnt_q <= wdata;
        else if (ld_wr)     cnt_q <= rld_q;
        else if (step)      cnt_q <= (wrap && rst_q) ? rld_q : dec_i;
    end

    // Reload register: software write only.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (wr_rld) rld_q <= wdata;
    end

    // Control bits: software writes, run clears on a non-restart wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {run_q, rst_q, ien_q, casc_q, frz_q} <= '0;
        end else if (wr_ctl) begin
            run_q  <= wdata[B_RUN];
            rst_q  <= wdata[B_RST];
            ien_q  <= wdata[B_IEN];
            casc_q <= wdata[B_CASC];
            frz_q  <= wdata[B_FRZ];
        end else if (wrap && !rst_q) begin
            run_q  <= 1'b0;
        end
    end

    // Pending flag and interrupt pulse: set on wrap, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= wrap && ien_q;
            if (wrap && ien_q)                  pend_q <= 1'b1;
            else if (wr_ctl && !wdata[B_PEND])  pend_q <= 1'b0;
        end
    end

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> cnt_q == $past(rld_q)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_i && !wr_cnt && !wr_ctl) |=> cnt_q == $past(cnt_q)); // R2
    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> pend_q); // R8
    AST_STOP_NORESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !rst_q && !wr_ctl) |=> !run_q); // R7
endmodule

// File: rtl/cascade_timer_bank.sv
// Module: top of the timer bank. Decodes the word bus, holds the
// configuration and watchdog state, and owns the one shared subtractor.
// Assumes word-aligned accesses and a prescaler reload of at least NUM.
module cascade_timer_bank
    import ctb_pkg::*;
#(
    parameter int NUM      = 4,
    parameter int CNT_W    = 32,
    parameter int PRE_W    = 12,
    parameter int ADDR_W   = 8,
    parameter int IRQ_BASE = 6,
    localparam int IDX_W   = (NUM > 1) ? $clog2(NUM) : 1,
    localparam int SEL_W   = ADDR_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              dbg_halt_i,
    output logic [NUM-1:0]    irq_o,
    output logic              wdog_n_o
);
    logic             wr_en, aligned;
    logic [PRE_W-1:0] pre_val, pre_rld;
    logic             tick;
    logic [IDX_W-1:0] idx;
    logic [NUM-1:0]   go, wrap_v, wr_cnt_v, wr_rld_v, wr_ctl_v;
    logic [CNT_W-1:0] cnt_a [NUM];
    logic [CNT_W-1:0] rld_a [NUM];
    logic [CTL_W-1:0] ctl_a [NUM];
    logic [CNT_W-1:0] dec_val;
    logic             prev_wrap_q, ovr_q, wdog_q;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_sel && bus_wr && aligned;

    ctb_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk(clk), .rst_n(rst_n),
        .wr_val(wr_en && bus_addr == ADDR_W'(8'h00)),
        .wr_rld(wr_en && bus_addr == ADDR_W'(8'h04)),
        .wdata(bus_wdata[PRE_W-1:0]),
        .val_o(pre_val), .rld_o(pre_rld), .tick_o(tick)
    );

    ctb_sequencer #(.NUM(NUM)) i_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .idx_o(idx), .go_o(go)
    );

    // The single subtractor: operand is the counter of the granted slot.
    assign dec_val = cnt_a[idx] - 1'b1;

    for (genvar k = 0; k < NUM; k++) begin : g_slot
        logic hit;
        assign hit         = wr_en && (bus_addr[ADDR_W-1:4] == SEL_W'(k+1));
        assign wr_cnt_v[k] = hit && (bus_addr[3:2] == 2'd0);
        assign wr_rld_v[k] = hit && (bus_addr[3:2] == 2'd1);
        assign wr_ctl_v[k] = hit && (bus_addr[3:2] == 2'd2);
        ctb_slot #(.CNT_W(CNT_W)) i_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_cnt(wr_cnt_v[k]), .wr_rld(wr_rld_v[k]), .wr_ctl(wr_ctl_v[k]),
            .wdata(bus_wdata), .go_i(go[k]),
            .chain_i((k == 0) ? 1'b0 : prev_wrap_q),
            .halt_i(dbg_halt_i && !ovr_q), .dec_i(dec_val),
            .cnt_o(cnt_a[k]), .rld_o(rld_a[k]), .ctl_o(ctl_a[k]),
            .wrap_o(wrap_v[k]), .irq_o(irq_o[k])
        );
    end

    // Carry the wrap of the slot served this cycle to the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_wrap_q <= 1'b0;
        else        prev_wrap_q <= |wrap_v;
    end

    // Freeze-override bit of the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else if (wr_en && bus_addr == ADDR_W'(8'h08)) ovr_q <= bus_wdata[CFG_OVR];
    end

    // Watchdog latch: set by the last slot wrapping, cleared by its load write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          wdog_q <= 1'b0;
        else if (wrap_v[NUM-1])                              wdog_q <= 1'b1;
        else if (wr_ctl_v[NUM-1] && bus_wdata[B_LOAD])       wdog_q <= 1'b0;
    end
    assign wdog_n_o = !wdog_q;

    // Read mux over the fixed words and the slot windows.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            if (bus_addr == ADDR_W'(8'h00)) bus_rdata = CNT_W'(pre_val);
            if (bus_addr == ADDR_W'(8'h04)) bus_rdata = CNT_W'(pre_rld);
            if (bus_addr == ADDR_W'(8'h08))
                bus_rdata = CNT_W'({ovr_q, 1'b1, 5'(IRQ_BASE), 3'(NUM)});
            for (int k = 0; k < NUM; k++) begin
                if (bus_addr[ADDR_W-1:4] == SEL_W'(k+1)) begin
                    case (bus_addr[3:2])
                        2'd0:    bus_rdata = cnt_a[k];
                        2'd1:    bus_rdata = rld_a[k];
                        2'd2:    bus_rdata = CNT_W'(ctl_a[k]);
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    AST_WDOG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdog_n_o) |-> $past(wrap_v[NUM-1])); // R10
    AST_ONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wrap_v)); // R2
endmodule

// File: tb/test_cascade_timer_bank.sv
module test_cascade_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt_i = 1'b0;
    logic [3:0]  irq_o;
    logic        wdog_n_o;
    int n_chk = 0, n_err = 0, cyc = 0;

    cascade_timer_bank i_cascade_timer_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_halt_i(dbg_halt_i), .irq_o(irq_o), .wdog_n_o(wdog_n_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] a_cnt(int n); return 8'(8'h10 + 16*n); endfunction
    function automatic logic [7:0] a_rld(int n); return 8'(8'h14 + 16*n); endfunction
    function automatic logic [7:0] a_ctl(int n); return 8'(8'h18 + 16*n); endfunction
    function automatic int period(int l, int p); return (l + 1) * (p + 1); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic irq_gap(int k, output int gap);
        int t0 = -1;
        gap = -1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (irq_o[k]) begin
                if (t0 < 0) t0 = cyc;
                else begin gap = cyc - t0; break; end
            end
        end
    endtask

    task automatic set_pre(int p);
        wr(8'h04, 32'(p));
        wr(8'h00, 32'(p));
    endtask

    initial begin
        #(4 * 190000);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, e;
        int g;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13 reset state
        rd(8'h08, d); chk("R13 cfg", d, 32'h134);
        rd(8'h04, d); chk("R13 pre reload", d, 32'hFFF);
        for (int n = 0; n < 4; n++) begin
            rd(a_ctl(n), d); chk("R13 ctl", d, 0);
            rd(a_cnt(n), d); chk("R13 cnt", d, 0);
        end
        chk("R13 wdog", 32'(wdog_n_o), 1);
        chk("R13 irq", 32'(irq_o), 0);

        // R1 prescaler reload readback, R4 counter access, R5 load
        wr(8'h04, 32'h9); rd(8'h04, d); chk("R1 pre reload rw", d, 32'h9);
        wr(a_cnt(1), 32'hABCD); rd(a_cnt(1), d); chk("R4 cnt rw", d, 32'hABCD);
        wr(a_rld(1), 32'h1234); wr(a_ctl(1), 32'h04);
        rd(a_cnt(1), d); chk("R5 load copies", d, 32'h1234);
        rd(a_ctl(1), d); chk("R5 load reads 0", d, 0);

        // R11 configuration word
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R11 cfg ovr set", d, 32'h334);
        wr(8'h08, 0); rd(8'h08, d); chk("R11 cfg ovr clr", d, 32'h134);

        // R6 R3 R1 random periods
        for (int t = 0; t < 6; t++) begin
            int l = $urandom_range(0, 5);
            int p = $urandom_range(4, 9);
            wr(a_ctl(0), 0);
            set_pre(p);
            wr(a_rld(0), 32'(l));
            wr(a_ctl(0), 32'h0F);
            irq_gap(0, g);
            chk("R6 R3 irq period", 32'(g), 32'(period(l, p)));
        end
        // R8 pulse width
        @(negedge clk); chk("R8 pulse one clock", 32'(irq_o[0]), 0);
        wr(a_ctl(0), 0);

        // R8 pending flag
        set_pre(4);
        wr(a_rld(0), 1); wr(a_ctl(0), 32'h0F);
        irq_gap(0, g);
        rd(a_ctl(0), d); chk("R8 pending set", d, 32'h1B);
        wr(a_ctl(0), 32'h1A); rd(a_ctl(0), d); chk("R8 write1 keeps", d, 32'h1A);
        wr(a_ctl(0), 32'h0A); rd(a_ctl(0), d); chk("R8 write0 clears", d, 32'h0A);
        wr(a_ctl(0), 32'h10); rd(a_ctl(0), d); chk("R8 write1 no set", d, 0);
        wr(a_ctl(0), 32'h07);
        g = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (irq_o[0]) g++; end
        chk("R8 ie0 no pulse", 32'(g), 0);
        rd(a_ctl(0), d); chk("R8 ie0 no pending", d, 32'h03);
        wr(a_ctl(0), 0);

        // R9 cascade
        wr(a_rld(0), 2); wr(a_rld(1), 1);
        wr(a_ctl(1), 32'h2F); wr(a_ctl(0), 32'h0F);
        irq_gap(1, g); chk("R9 cascade period", 32'(g), 32'(period(2, 0) * period(1, 4)));
        wr(a_ctl(0), 0); wr(a_ctl(1), 0);
        wr(a_rld(0), 7); wr(a_ctl(0), 32'h25);
        wait_cyc(30); rd(a_cnt(0), d); chk("R9 timer0 cascade holds", d, 7);
        wr(a_ctl(0), 0);
        wr(a_rld(1), 3); wr(a_ctl(1), 32'h25);
        wait_cyc(30); rd(a_cnt(1), d); chk("R9 stopped predecessor", d, 3);
        wr(a_ctl(1), 0);

        // R12 debug freeze, R2 exact step rate
        wr(a_rld(2), 1000); wr(a_ctl(2), 32'h47);
        dbg_halt_i = 1;
        rd(a_cnt(2), d); wait_cyc(40); rd(a_cnt(2), e);
        chk("R12 frozen", e, d);
        wr(8'h08, 32'h200);
        rd(a_cnt(2), d); wait_cyc(39); rd(a_cnt(2), e);
        chk("R12 R2 override runs", d - e, 8);
        wr(8'h08, 0); dbg_halt_i = 0;
        rd(a_cnt(2), d); wait_cyc(49); rd(a_cnt(2), e);
        chk("R2 one step per tick", d - e, 10);
        wr(a_ctl(2), 0);

        // R10 R7 watchdog
        wr(a_rld(3), 5); wr(a_ctl(3), 32'h05);
        wait_cyc(10); chk("R10 wdog high early", 32'(wdog_n_o), 1);
        wait_cyc(60); chk("R10 wdog low on expiry", 32'(wdog_n_o), 0);
        rd(a_ctl(3), d); chk("R7 run cleared", d, 0);
        rd(a_cnt(3), d); chk("R7 counter all ones", d, 32'hFFFF_FFFF);
        wr(a_ctl(3), 32'h05); chk("R10 load clears", 32'(wdog_n_o), 1);
        g = 0;
        for (int i = 0; i < 8; i++) begin
            wait_cyc(15);
            if (!wdog_n_o) g++;
            wr(a_ctl(3), 32'h05);
        end
        chk("R10 kicked stays high", 32'(g), 0);
        wr(a_ctl(3), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule